// File: doc/BRIEF.md
# Single-Precision NaN Screen and Quieter

This combinational unit looks at one 32-bit binary floating-point word and sorts it into three classes: not-a-number of any kind, quiet NaN, and signaling NaN. Beside the class flags it returns a cleaned-up copy of the word. If the input is a signaling NaN, the copy is quiet. Every other input appears on that output bit for bit.

Three elaboration parameters fix the interpretation:
- `QUIET_INVERT` sets the meaning of the top fraction bit. In the usual convention a set bit marks a quiet NaN. In the inverted convention a set bit marks a signaling NaN.
- `SIGNALING_EN` decides whether signaling NaNs exist at all.
- `DNAN_SEL` picks the canonical NaN word. That word is driven on a constant output so that neighbouring arithmetic can use it for generated results.

The unit is meant to sit in front of an arithmetic datapath. It has no clock and no state. The outputs follow the input within the same cycle.

Top module: `nan_screen`

## Requirements
- R1: `is_nan_o` is 1 exactly when bits [30:23] are all ones and bits [22:0] are not all zero, under every configuration.
- R2: With `QUIET_INVERT`=0 and `SIGNALING_EN`=1, a NaN is quiet when bit 22 is 1 and signaling when bit 22 is 0.
- R3: With `QUIET_INVERT`=1 and `SIGNALING_EN`=1, the tests swap: a NaN is signaling when bit 22 is 1 and quiet when bit 22 is 0 (bits [21:0] then carry the non-zero payload).
- R4: With `SIGNALING_EN`=0, `is_snan_o` is always 0 and `is_qnan_o` equals `is_nan_o`.
- R5: With `QUIET_INVERT`=0, a signaling NaN leaves `quieted_o` as the input with bit 22 forced to 1; sign and bits [21:0] are kept.
- R6: With `QUIET_INVERT`=1, a signaling NaN produces `quieted_o` = `default_nan_o` = 0x7FBFFFFF.
- R7: Any input that is not a signaling NaN appears unchanged on `quieted_o`.
- R8: `default_nan_o` is 0x7FFFFFFF for `DNAN_ALL_ONES`, 0x7FC00000 for `DNAN_POS_QUIET` and 0xFFC00000 for `DNAN_NEG_QUIET` when `QUIET_INVERT`=0; it is 0x7FBFFFFF whenever `QUIET_INVERT`=1.
- R9: Zeros and infinities of either sign (bits [22:0] all zero) raise none of the three flags and pass through unchanged.
- R10: `is_qnan_o` and `is_snan_o` are never 1 together, and either being 1 implies `is_nan_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | 32 | Floating-point word to classify |
| is_nan_o | output | 1 | Word is a NaN of any kind |
| is_qnan_o | output | 1 | Word is a quiet NaN |
| is_snan_o | output | 1 | Word is a signaling NaN |
| quieted_o | output | 32 | Input with a signaling NaN turned quiet |
| default_nan_o | output | 32 | Canonical NaN for this configuration |

## Verification
The unit holds no state, so a wrong internal decision can only be a wrong decode. It shows at the ports in the same cycle as the input that triggers it.

- A swapped polarity shows as exchanged quiet and signaling flags on NaNs with bit 22 set.
- A misplaced exponent or fraction slice shows on the borderline words: infinities, 0x7F800001 and 0x7FC00000.
- A wrong quieting rule corrupts the sign or payload on `quieted_o`.

The stimulus applies each of these borderline words to four configurations side by side, so any of these faults shows up on the first affected vector.

// File: rtl/nan_screen_pkg.sv
package nan_screen_pkg;

    // Choice of canonical NaN word (used when the quiet bit has usual polarity)
    typedef enum logic [1:0] {
        DNAN_ALL_ONES  = 2'd0,  // positive, every fraction bit set
        DNAN_POS_QUIET = 2'd1,  // positive, only the top fraction bit set
        DNAN_NEG_QUIET = 2'd2   // negative, only the top fraction bit set
    } dnan_sel_e;

endpackage

// File: rtl/nan_screen_classify.sv
module nan_screen_classify #(
    parameter int EXP_W        = 8,
    parameter int FRAC_W       = 23,
    parameter bit QUIET_INVERT = 1'b0,
    parameter bit SIGNALING_EN = 1'b1
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  nan_o,
    output logic                  qnan_o,
    output logic                  snan_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;

    logic exp_full;
    logic frac_any;
    logic top_frac;

    assign exp_full = &word_i[WORD_W-2:FRAC_W];
    assign frac_any = |word_i[FRAC_W-1:0];
    assign top_frac = word_i[FRAC_W-1];

    always_comb begin
        nan_o = exp_full & frac_any;
        if (!SIGNALING_EN) begin
            qnan_o = nan_o;
            snan_o = 1'b0;
        end else if (QUIET_INVERT) begin
            qnan_o = nan_o & ~top_frac;
            snan_o = nan_o &  top_frac;
        end else begin
            qnan_o = nan_o &  top_frac;
            snan_o = nan_o & ~top_frac;
        end
    end

endmodule

// File: rtl/nan_screen_pattern.sv
module nan_screen_pattern
    import nan_screen_pkg::*;
#(
    parameter int        EXP_W        = 8,
    parameter int        FRAC_W       = 23,
    parameter bit        QUIET_INVERT = 1'b0,
    parameter dnan_sel_e DNAN_SEL     = DNAN_POS_QUIET
) (
    output logic [EXP_W+FRAC_W:0] pattern_o
);
    localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
    localparam logic [FRAC_W-2:0] LOW_ONES  = {(FRAC_W-1){1'b1}};
    localparam logic [FRAC_W-2:0] LOW_ZEROS = {(FRAC_W-1){1'b0}};

    generate
        if (QUIET_INVERT) begin : g_inv
            assign pattern_o = {1'b0, EXP_ONES, 1'b0, LOW_ONES};
        end else if (DNAN_SEL == DNAN_ALL_ONES) begin : g_ones
            assign pattern_o = {1'b0, EXP_ONES, 1'b1, LOW_ONES};
        end else if (DNAN_SEL == DNAN_NEG_QUIET) begin : g_neg
            assign pattern_o = {1'b1, EXP_ONES, 1'b1, LOW_ZEROS};
        end else begin : g_pos
            assign pattern_o = {1'b0, EXP_ONES, 1'b1, LOW_ZEROS};
        end
    endgenerate

endmodule

// File: rtl/nan_screen_quiet.sv
module nan_screen_quiet #(
    parameter int EXP_W        = 8,
    parameter int FRAC_W       = 23,
    parameter bit QUIET_INVERT = 1'b0
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    input  logic                  snan_i,
    input  logic [EXP_W+FRAC_W:0] dflt_i,
    output logic [EXP_W+FRAC_W:0] quieted_o
);
    localparam logic [EXP_W+FRAC_W:0] QBIT_MASK =
        {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    always_comb begin
        quieted_o = word_i;
        if (snan_i) begin
            quieted_o = QUIET_INVERT ? dflt_i : (word_i | QBIT_MASK);
        end
    end

endmodule

// File: rtl/nan_screen.sv
module nan_screen
    import nan_screen_pkg::*;
#(
    parameter int        EXP_W        = 8,
    parameter int        FRAC_W       = 23,
    parameter bit        QUIET_INVERT = 1'b0,
    parameter bit        SIGNALING_EN = 1'b1,
    parameter dnan_sel_e DNAN_SEL     = DNAN_POS_QUIET
) (
    input  logic [EXP_W+FRAC_W:0] word_i,
    output logic                  is_nan_o,
    output logic                  is_qnan_o,
    output logic                  is_snan_o,
    output logic [EXP_W+FRAC_W:0] quieted_o,
    output logic [EXP_W+FRAC_W:0] default_nan_o
);
    logic snan_w;

    nan_screen_classify #(
        .EXP_W       (EXP_W),
        .FRAC_W      (FRAC_W),
        .QUIET_INVERT(QUIET_INVERT),
        .SIGNALING_EN(SIGNALING_EN)
    ) u_classify (
        .word_i(word_i),
        .nan_o (is_nan_o),
        .qnan_o(is_qnan_o),
        .snan_o(snan_w)
    );

    nan_screen_pattern #(
        .EXP_W       (EXP_W),
        .FRAC_W      (FRAC_W),
        .QUIET_INVERT(QUIET_INVERT),
        .DNAN_SEL    (DNAN_SEL)
    ) u_pattern (
        .pattern_o(default_nan_o)
    );

    nan_screen_quiet #(
        .EXP_W       (EXP_W),
        .FRAC_W      (FRAC_W),
        .QUIET_INVERT(QUIET_INVERT)
    ) u_quiet (
        .word_i   (word_i),
        .snan_i   (snan_w),
        .dflt_i   (default_nan_o),
        .quieted_o(quieted_o)
    );

    assign is_snan_o = snan_w;

endmodule

// File: rtl/nan_screen_chk.sv
module nan_screen_chk #(
    parameter int EXP_W        = 8,
    parameter int FRAC_W       = 23,
    parameter bit QUIET_INVERT = 1'b0,
    parameter bit SIGNALING_EN = 1'b1
) (
    input logic [EXP_W+FRAC_W:0] word_i,
    input logic                  is_nan_o,
    input logic                  is_qnan_o,
    input logic                  is_snan_o,
    input logic [EXP_W+FRAC_W:0] quieted_o,
    input logic [EXP_W+FRAC_W:0] default_nan_o
);
    localparam int TOP = EXP_W + FRAC_W;

    always_comb begin
        AST_NAN_FIELDS: assert (is_nan_o == ((&word_i[TOP-1:FRAC_W]) && (|word_i[FRAC_W-1:0])))
            else $error("nan flag disagrees with fields"); // R1
        AST_CLASS_EXCLUSIVE: assert (!(is_qnan_o && is_snan_o))
            else $error("quiet and signaling both set"); // R10
        AST_CLASS_IMPLIES_NAN: assert (!(is_qnan_o || is_snan_o) || is_nan_o)
            else $error("class flag without nan"); // R10
        AST_NAN_HAS_CLASS: assert (!is_nan_o || is_qnan_o || is_snan_o)
            else $error("nan without class"); // R2
        AST_NO_SIGNALING: assert (SIGNALING_EN || !is_snan_o)
            else $error("signaling reported while disabled"); // R4
        AST_PASS_THROUGH: assert (is_snan_o || (quieted_o == word_i))
            else $error("non-signaling word altered"); // R7
        AST_QUIET_KEEPS_PAYLOAD: assert (!is_snan_o || QUIET_INVERT ||
                ((quieted_o[TOP] == word_i[TOP]) && quieted_o[FRAC_W-1] &&
                 (quieted_o[FRAC_W-2:0] == word_i[FRAC_W-2:0])))
            else $error("usual quieting lost sign or payload"); // R5
        AST_QUIET_TO_DEFAULT: assert (!is_snan_o || !QUIET_INVERT || (quieted_o == default_nan_o))
            else $error("inverted quieting not default"); // R6
        AST_INF_ZERO_CLEAN: assert ((|word_i[FRAC_W-1:0]) || !(is_nan_o || is_qnan_o || is_snan_o))
            else $error("zero or infinity flagged"); // R9
    end

endmodule

bind nan_screen nan_screen_chk #(
    .EXP_W       (EXP_W),
    .FRAC_W      (FRAC_W),
    .QUIET_INVERT(QUIET_INVERT),
    .SIGNALING_EN(SIGNALING_EN)
) u_chk (
    .word_i       (word_i),
    .is_nan_o     (is_nan_o),
    .is_qnan_o    (is_qnan_o),
    .is_snan_o    (is_snan_o),
    .quieted_o    (quieted_o),
    .default_nan_o(default_nan_o)
);

// File: tb/nan_screen_test.sv
module nan_screen_test;
    import nan_screen_pkg::*;

    localparam int NCFG = 4;

    typedef struct {
        int          cfg;
        logic [31:0] word;
        logic        nan;
        logic        q;
        logic        s;
        logic [31:0] quieted;
        logic [31:0] dflt;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [31:0] stim = 32'h0;

    logic        nan_o  [NCFG];
    logic        q_o    [NCFG];
    logic        s_o    [NCFG];
    logic [31:0] qt_o   [NCFG];
    logic [31:0] dn_o   [NCFG];

    // cfg0: usual polarity, positive quiet default
    nan_screen #(.QUIET_INVERT(1'b0), .SIGNALING_EN(1'b1), .DNAN_SEL(DNAN_POS_QUIET)) uut (
        .word_i(stim), .is_nan_o(nan_o[0]), .is_qnan_o(q_o[0]), .is_snan_o(s_o[0]),
        .quieted_o(qt_o[0]), .default_nan_o(dn_o[0]));
    // cfg1: inverted polarity
    nan_screen #(.QUIET_INVERT(1'b1), .SIGNALING_EN(1'b1), .DNAN_SEL(DNAN_POS_QUIET)) uut_inv (
        .word_i(stim), .is_nan_o(nan_o[1]), .is_qnan_o(q_o[1]), .is_snan_o(s_o[1]),
        .quieted_o(qt_o[1]), .default_nan_o(dn_o[1]));
    // cfg2: signaling disabled, all-ones default
    nan_screen #(.QUIET_INVERT(1'b0), .SIGNALING_EN(1'b0), .DNAN_SEL(DNAN_ALL_ONES)) uut_nosig (
        .word_i(stim), .is_nan_o(nan_o[2]), .is_qnan_o(q_o[2]), .is_snan_o(s_o[2]),
        .quieted_o(qt_o[2]), .default_nan_o(dn_o[2]));
    // cfg3: usual polarity, negative quiet default
    nan_screen #(.QUIET_INVERT(1'b0), .SIGNALING_EN(1'b1), .DNAN_SEL(DNAN_NEG_QUIET)) uut_neg (
        .word_i(stim), .is_nan_o(nan_o[3]), .is_qnan_o(q_o[3]), .is_snan_o(s_o[3]),
        .quieted_o(qt_o[3]), .default_nan_o(dn_o[3]));

    item_t sb[$];
    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Expected behaviour written from the requirements
    function automatic item_t expect_of(int cfg, logic [31:0] w);
        item_t e;
        bit inv, sig_en;
        inv    = (cfg == 1);
        sig_en = (cfg != 2);
        e.cfg  = cfg;
        e.word = w;
        e.nan  = (w[30:23] == 8'hFF) && (w[22:0] != 23'd0);          // R1
        case (cfg)                                                   // R8
            1:       e.dflt = 32'h7FBFFFFF;
            2:       e.dflt = 32'h7FFFFFFF;
            3:       e.dflt = 32'hFFC00000;
            default: e.dflt = 32'h7FC00000;
        endcase
        if (!sig_en) begin                                           // R4
            e.q = e.nan; e.s = 1'b0;
        end else if (inv) begin                                      // R3
            e.q = e.nan && !w[22]; e.s = e.nan && w[22];
        end else begin                                               // R2
            e.q = e.nan && w[22]; e.s = e.nan && !w[22];
        end
        if (e.s) e.quieted = inv ? 32'h7FBFFFFF : (w | 32'h00400000); // R5 R6
        else     e.quieted = w;                                      // R7
        return e;
    endfunction

    function automatic string class_tag(item_t e);
        if (e.word[22:0] == 23'd0) return "R9";
        if (e.cfg == 2) return "R4";
        if (e.cfg == 1) return "R3";
        return "R2";
    endfunction

    // Driver: change the input at the falling edge and queue expectations
    task automatic apply(logic [31:0] w);
        @(negedge clk);
        stim = w;
        for (int c = 0; c < NCFG; c++) sb.push_back(expect_of(c, w));
    endtask

    // Monitor: outputs are settled by the rising edge; compare and retire
    always @(posedge clk) begin
        while (sb.size() > 0) begin
            item_t e;
            bit bad;
            string qtag;
            e = sb.pop_front();
            bad = 1'b0;
            applied++;
            qtag = e.s ? ((e.cfg == 1) ? "R6" : "R5") : "R7";
            if (nan_o[e.cfg] !== e.nan) begin
                bad = 1'b1;
                $display("FAIL R1 cfg%0d word=%h nan actual=%b expected=%b", e.cfg, e.word, nan_o[e.cfg], e.nan);
            end
            if (q_o[e.cfg] !== e.q || s_o[e.cfg] !== e.s) begin
                bad = 1'b1;
                $display("FAIL %s cfg%0d word=%h q/s actual=%b%b expected=%b%b (R10)", class_tag(e), e.cfg,
                         e.word, q_o[e.cfg], s_o[e.cfg], e.q, e.s);
            end
            if (qt_o[e.cfg] !== e.quieted) begin
                bad = 1'b1;
                $display("FAIL %s cfg%0d word=%h quieted actual=%h expected=%h", qtag, e.cfg, e.word,
                         qt_o[e.cfg], e.quieted);
            end
            if (dn_o[e.cfg] !== e.dflt) begin
                bad = 1'b1;
                $display("FAIL R8 cfg%0d default actual=%h expected=%h", e.cfg, dn_o[e.cfg], e.dflt);
            end
            if (bad) miscompares++;
        end
    end

    // Watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog all requirements actual=%0d cycles expected<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 zeros and infinities
        apply(32'h00000000); apply(32'h80000000);
        apply(32'h7F800000); apply(32'hFF800000);
        // R1 R2 R3 boundary NaNs
        apply(32'h7F800001); apply(32'h7FBFFFFF);
        apply(32'h7FC00000); apply(32'h7FFFFFFF);
        apply(32'hFFC00001); apply(32'hFF800123);
        apply(32'hFFFFFFFF); apply(32'hFFA5A5A5);
        // R7 ordinary numbers near the edges
        apply(32'h7F7FFFFF); apply(32'h00000001);
        apply(32'h3F800000); apply(32'h807FFFFF);
        apply(32'h7F400000);
        // Sweep with forced all-ones exponent and pseudo-random fraction/sign
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            if (i % 3 == 0) apply(lfsr);
            else            apply({lfsr[31], 8'hFF, lfsr[22:0]});
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

endmodule